// File: doc/BRIEF.md
# Prescaled Auto-Reload Down-Counter Timer

This block is a 32-bit periodic timer with a small register window. A reference tick enable goes into a power-of-two prescaler. The prescaler divides it by 2^(exponent+1), with the 3-bit exponent giving dividers from 2 to 256. Each divided tick lowers a down-counter by one. When the counter is at zero, the next divided tick counts as an expiry. An expiry raises a one-cycle interrupt. The counter then either restarts from the load value or stops the timer.

Software sets the load value and then writes the control word with the run bit set. After that it can read the live count at any time. Running and counting are separate from the module enable. Clearing the run bit freezes the count, and the register window stays readable and writable. A load of all ones with auto-reload gives a free-running counter that wraps as an unsigned 32-bit value.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the control word, load value and count all read 0, and `irq` is low.
- R2: The register window has three offsets. Offset 0x00 is control: bit 0 run, bit 1 auto-reload, bits 4:2 divide exponent, bit 5 module enable, bit 6 free flag. Offset 0x04 is load and offset 0x08 is the live count. Control bits above bit 6 read 0, other offsets read 0, and written control fields read back unchanged.
- R3: A control write that sets run while run is 0 loads the counter from the load value and clears the prescaler in the same cycle.
- R4: With run and enable set, the first `irq` comes after (load+1)·2^(exponent+1) reference ticks, counted from the start write.
- R5: `irq` is high for exactly one clock cycle per expiry.
- R6: With auto-reload set, the counter reloads from the load value at each expiry, and expiries repeat every (load+1)·2^(exponent+1) reference ticks.
- R7: With auto-reload clear, an expiry clears the run bit and leaves the count at 0. No further `irq` follows.
- R8: While run or module enable is 0, the count holds its value and no `irq` is raised. The registers stay readable and writable.
- R9: The count register returns the live counter value, which drops by one on every divided tick.
- R10: A load write during a count does not change the current count. The new value is used at the next reload, and a load of 0xFFFFFFFF reloads past 0 as an unsigned wrap.
- R11: The free flag is stored and read back but has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference clock tick enable, one cycle per reference period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
The period is swept over all eight divide exponents and three load values. The reference tick is gapped in a pattern that differs for each setting, so the bench counts only cycles in which the tick is present. This separates an off-by-one in the prescaler from one in the counter, and both from a count of clock cycles instead of ticks. The first and second expiry of each setting are compared with (load+1)·2^(exponent+1) and twice that, so a wrong reload shows up. The bench also reads back the live count and changes the load value mid-count, which exposes reloads that happen too early. Stops by clearing run, by module enable and by one-shot expiry show whether counting is gated by the right bits.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int EXP_W = 3;
  localparam int PRE_W = 1 << EXP_W;   // divider up to 2^(2^EXP_W)

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_LOAD  = 'h04;
  localparam int OFS_COUNT = 'h08;

  // Packed MSB first so bit 0 is run, bit 6 is the free flag.
  typedef struct packed {
    logic             free_run;
    logic             mod_en;
    logic [EXP_W-1:0] div_exp;
    logic             auto_rld;
    logic             run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             ref_tick,
  input  logic [EXP_W-1:0] div_exp,
  output logic             ptick
);
  logic [PRE_W-1:0] pre_q, pre_d, lim;
  logic [EXP_W:0]   shamt;
  logic [PRE_W:0]   span;
  logic             adv, pre_en;

  always_comb begin
    shamt  = {1'b0, div_exp} + (EXP_W+1)'(1);
    span   = (PRE_W+1)'(1) << shamt;
    lim    = PRE_W'(span - (PRE_W+1)'(1));
    adv    = active & ref_tick;
    ptick  = adv & (pre_q >= lim);
    pre_en = clear | adv;
    if (clear)      pre_d = '0;
    else if (ptick) pre_d = '0;
    else            pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             ptick,
  input  logic             auto_rld,
  input  logic [CNT_W-1:0] load,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero, cnt_en, irq_q;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = active & ptick & at_zero & ~start;
    cnt_en  = start | (active & ptick);
    if (start)        cnt_d = load;
    else if (at_zero) cnt_d = auto_rld ? load : '0;
    else              cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= expire;
  end

  assign count = cnt_q;
  assign irq   = irq_q;
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              stop_req,
  input  logic [CNT_W-1:0]  count,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  load,
  output logic              start,
  output logic [CNT_W-1:0]  rdata
);
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] load_q;
  logic             sel_ctrl, sel_load, sel_count, hit_ctrl, hit_load, ctrl_en;

  always_comb begin
    sel_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    sel_load  = (addr == ADDR_W'(OFS_LOAD));
    sel_count = (addr == ADDR_W'(OFS_COUNT));
    hit_ctrl  = we & sel_ctrl;
    hit_load  = we & sel_load;
    start     = hit_ctrl & wdata[0] & ~ctrl_q.run;
    ctrl_en   = hit_ctrl | stop_req;
    ctrl_d    = ctrl_q;
    if (stop_req) ctrl_d.run = 1'b0;
    if (hit_ctrl) ctrl_d = tmr_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        load_q <= '0;
    else if (hit_load) load_q <= wdata;
  end

  always_comb begin
    if (sel_ctrl)       rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
    else if (sel_load)  rdata = load_q;
    else if (sel_count) rdata = count;
    else                rdata = '0;
  end

  assign ctrl = ctrl_q;
  assign load = load_q;
endmodule

// File: rtl/prescaled_reload_timer.sv
`timescale 1ns/1ps
module prescaled_reload_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] load_q, count_q;
  logic             start_pulse, active, ptick, expire, stop_req;

  assign active   = ctrl.run & ctrl.mod_en;
  assign stop_req = expire & ~ctrl.auto_rld;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stop_req (stop_req),
    .count    (count_q),
    .ctrl     (ctrl),
    .load     (load_q),
    .start    (start_pulse),
    .rdata    (reg_rdata)
  );

  tmr_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_pulse),
    .active   (active),
    .ref_tick (ref_tick),
    .div_exp  (ctrl.div_exp),
    .ptick    (ptick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_pulse),
    .active   (active),
    .ptick    (ptick),
    .auto_rld (ctrl.auto_rld),
    .load     (load_q),
    .count    (count_q),
    .expire   (expire),
    .irq      (irq)
  );
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             active,
  input logic             start,
  input logic             ptick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5

  AST_IRQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(active)); // R8

  AST_START_TAKES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(load))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(count)); // R8

  AST_TICK_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ptick && count != '0 && !start) |=> (count == $past(count) - CNT_W'(1))); // R9
endmodule

bind prescaled_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq    (irq),
  .active (active),
  .start  (start_pulse),
  .ptick  (ptick),
  .count  (count_q),
  .load   (load_q)
);

// File: tb/tb_prescaled_reload_timer.sv
`timescale 1ns/1ps
module tb_prescaled_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_LOAD = 8'h04, A_CNT = 8'h08;

  prescaled_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    ref_tick = 1'b0; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic step(logic r);
    ref_tick = r;
    @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 register map and readback, R11 free flag stored
    wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); chk("R2 ctrl upper bits", v, 32'h7E);
    wr(A_CTRL, 32'h0000_0054); rd(A_CTRL, v); chk("R2,R11 ctrl fields", v, 32'h54);
    wr(A_LOAD, 32'hA5A5_5A5A); rd(A_LOAD, v); chk("R2 load", v, 32'hA5A5_5A5A);
    rd(8'h0C, v); chk("R2 unused offset", v, 0);
    rd(8'h10, v); chk("R2 unused offset", v, 0);
    wr(A_CTRL, 32'h0);

    // R4/R5/R6/R11 period sweep with gapped reference ticks
    for (int e = 0; e < 8; e++) begin
      for (int l = 0; l < 3; l++) begin
        int n, ticks, got;
        logic prev, r;
        n = (l + 1) << (e + 1);
        wr(A_LOAD, l);
        wr(A_CTRL, (((e + l) % 2) << 6) | 32'h20 | (e << 2) | 32'h3);
        ticks = 0; got = 0; prev = 1'b0;
        for (int c = 0; c < 4 * n + 40 && got < 2; c++) begin
          r = ((c * 3 + e + l) % 4) != 0;
          step(r);
          if (r) ticks++;
          if (prev) chk("R5 pulse width", {31'b0, irq}, 0);
          if (irq) begin
            got++;
            chk(got == 1 ? "R4,R11 first expiry" : "R6 repeat expiry", ticks, got * n);
          end
          prev = irq;
        end
        if (got < 2) chk("R6 expiry count", got, 2);
        wr(A_CTRL, 32'h20);
      end
    end

    // R3 start load, R9 live count
    wr(A_LOAD, 100);
    wr(A_CTRL, 32'h23);
    rd(A_CNT, v); chk("R3 start loads", v, 100);
    repeat (10) step(1'b1);
    rd(A_CNT, v); chk("R9 live count", v, 95);
    repeat (10) step(1'b1);
    rd(A_CNT, v); chk("R9 live count", v, 90);

    // R10 load write mid-count, then reload and wrap
    wr(A_LOAD, 3);
    rd(A_CNT, v); chk("R10 count undisturbed", v, 90);
    for (int c = 0; c < 400; c++) begin step(1'b1); if (irq) break; end
    chk("R10 irq reached", {31'b0, irq}, 1);
    rd(A_CNT, v); chk("R10 new load used", v, 3);
    wr(A_LOAD, 32'hFFFF_FFFF);
    for (int c = 0; c < 40; c++) begin step(1'b1); if (irq) break; end
    rd(A_CNT, v); chk("R10 wrap reload", v, 32'hFFFF_FFFF);
    repeat (2) step(1'b1);
    rd(A_CNT, v); chk("R10 wrap decrement", v, 32'hFFFF_FFFE);

    // R8 halt by clearing run, module still accessible
    wr(A_CTRL, 32'h22);
    rd(A_CNT, c1);
    seen = 0;
    for (int c = 0; c < 20; c++) begin step(1'b1); if (irq) seen++; end
    rd(A_CNT, v); chk("R8 run clear holds count", v, c1);
    chk("R8 no irq when stopped", seen, 0);
    // R8 run set with module enable clear
    wr(A_LOAD, 1);
    wr(A_CTRL, 32'h03);
    seen = 0;
    for (int c = 0; c < 20; c++) begin step(1'b1); if (irq) seen++; end
    rd(A_CNT, v); chk("R8 disabled holds count", v, 1);
    chk("R8 no irq when disabled", seen, 0);
    rd(A_LOAD, v); chk("R8 registers accessible", v, 1);
    wr(A_CTRL, 32'h0);

    // R7 one-shot
    wr(A_LOAD, 2);
    wr(A_CTRL, 32'h21);
    seen = 0;
    for (int c = 0; c < 30; c++) begin step(1'b1); seen++; if (irq) break; end
    chk("R7 one-shot expiry time", seen, 6);
    rd(A_CTRL, v); chk("R7 run cleared", v & 32'h1, 0);
    rd(A_CNT, v);  chk("R7 count at zero", v, 0);
    seen = 0;
    for (int c = 0; c < 30; c++) begin step(1'b1); if (irq) seen++; end
    chk("R7 no further irq", seen, 0);
    rd(A_CNT, v);  chk("R7 count stays zero", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule